// File: doc/BRIEF.md
# Sequential Booth Multiplier

This block multiplies two signed two's-complement integers of `WIDTH` bits and returns their full `2*WIDTH`-bit signed product. It retires one multiplier bit per clock. It recodes runs of ones in the multiplier: each step looks at the current low multiplier bit and the bit shifted out before it, and chooses to subtract the multiplicand, add it, or do neither. The accumulator, the multiplier register and a one-bit history register are then shifted right together as one word. The shift is arithmetic, so the accumulator's sign bit is copied in from the left. Because the partial product moves right, the multiplicand is never shifted.

A caller drives both operands and pulses `start` for one cycle while `busy` is low. The block captures the operands on that edge and raises `busy`. After exactly `WIDTH` step cycles it drops `busy` and raises `done` for a single cycle. From then on `product` holds the result until the next accepted start. The high half of `product` comes from the accumulator and the low half from the multiplier register.

The accumulator carries one guard bit above `WIDTH`. This keeps the most-negative-squared case exact. A parameter selects between a shared adder with a conditional complement and a separate adder and subtractor followed by a multiplexer.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is low captures both operands, and `busy` reads 1 after that clock edge.
- R3: Counting the accepting edge as edge 0, `busy` stays high after edges 1 to WIDTH-1, and `done` reads 1 and `busy` reads 0 after edge WIDTH.
- R4: `done` is high for exactly one cycle per accepted start.
- R5: After `done`, `product` equals the signed product of `multiplier` and `multiplicand`, as held at the accepting edge, in `2*WIDTH`-bit two's complement. This holds for positive, negative, mixed-sign and alternating-bit operands. A step whose current and previous multiplier bits are equal only shifts the accumulator.
- R6: The most negative value times itself gives the positive product 2^(2*WIDTH-2), and the most negative value times the most positive value gives the exact negative product.
- R7: A `start` pulse while `busy` is high is ignored: the step count, the `done` timing and the result are unchanged.
- R8: While the block is idle and `start` is low, `product` stays unchanged.
- R9: Changes on `multiplicand` or `multiplier` after the accepting edge have no effect on the result.
- R10: A zero operand in either position gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a multiplication |
| multiplicand | input | WIDTH | Signed multiplicand, captured on an accepted start |
| multiplier | input | WIDTH | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while step cycles are running |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product: accumulator bits above, multiplier register bits below |

## Verification
The assertions assume that `start` is sampled only at rising edges and that `rst_n` is held low long enough to clear every register. They also assume `start` is a single-cycle pulse whenever the block is idle. If `start` were held high, a new multiplication would begin the moment `done` fires, and the hold-while-idle property would not apply. The bench changes inputs only on falling edges and never holds `start` across an idle edge. It deliberately raises `start` while `busy` is high and changes the operands in the middle of a run, to test that both are ignored.

// File: rtl/booth_pkg.sv
package booth_pkg;

   // Action chosen for one step from the current and previous multiplier bits
   typedef enum logic [1:0] {
      BOOTH_NOP = 2'd0,
      BOOTH_ADD = 2'd1,
      BOOTH_SUB = 2'd2
   } booth_op_e;

   // Adder variants selectable at elaboration
   localparam int ADDER_SHARED = 0;
   localparam int ADDER_DUAL   = 1;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
   import booth_pkg::*;
(
   input  logic      cur_bit,
   input  logic      prev_bit,
   output booth_op_e op
);

   always_comb begin
      case ({cur_bit, prev_bit})
         2'b10:   op = BOOTH_SUB;   // entering a run of ones
         2'b01:   op = BOOTH_ADD;   // leaving a run of ones
         default: op = BOOTH_NOP;   // inside a run of ones or of zeros
      endcase
   end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
   parameter int WIDTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic load_en,
   output logic step_en
);

   localparam int CNT_W = $clog2(WIDTH + 1);

   logic [CNT_W-1:0] steps_left;
   logic             last_step;

   assign load_en   = start && !busy;
   assign step_en   = busy;
   assign last_step = (steps_left == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         done       <= 1'b0;
         steps_left <= '0;
      end else begin
         done <= 1'b0;
         if (load_en) begin
            busy       <= 1'b1;
            steps_left <= CNT_W'(WIDTH);
         end else if (busy) begin
            steps_left <= steps_left - CNT_W'(1);
            if (last_step) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));

   // R3
   step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last_step) |=> (busy && steps_left == $past(steps_left) - CNT_W'(1)));

   // R3
   finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && last_step) |=> (done && !busy));

   // R4
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !last_step) |=> (steps_left == $past(steps_left) - CNT_W'(1)));

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
   import booth_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = ADDER_SHARED
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en,
   input  logic               step_en,
   input  logic [WIDTH-1:0]   multiplicand,
   input  logic [WIDTH-1:0]   multiplier,
   output logic [2*WIDTH-1:0] product
);

   // Accumulator carries one guard bit so most-negative operands stay exact
   localparam int ACC_W = WIDTH + 1;

   logic [ACC_W-1:0] acc;
   logic [WIDTH-1:0] mreg;
   logic             hist;
   logic [ACC_W-1:0] mcand_x;
   logic [ACC_W-1:0] sum;
   booth_op_e        op;

   booth_recoder u_recoder (
      .cur_bit  (mreg[0]),
      .prev_bit (hist),
      .op       (op)
   );

   generate
      if (ADDER_STYLE == ADDER_SHARED) begin : g_shared_adder
         logic [ACC_W-1:0] operand;
         logic             cin;
         always_comb begin
            cin = (op == BOOTH_SUB);
            case (op)
               BOOTH_ADD: operand = mcand_x;
               BOOTH_SUB: operand = ~mcand_x;
               default:   operand = '0;
            endcase
            sum = acc + operand + ACC_W'(cin);
         end
      end else begin : g_dual_adder
         logic [ACC_W-1:0] add_res;
         logic [ACC_W-1:0] sub_res;
         always_comb begin
            add_res = acc + mcand_x;
            sub_res = acc - mcand_x;
            case (op)
               BOOTH_ADD: sum = add_res;
               BOOTH_SUB: sum = sub_res;
               default:   sum = acc;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         mreg    <= '0;
         hist    <= 1'b0;
         mcand_x <= '0;
      end else if (load_en) begin
         acc     <= '0;
         mreg    <= multiplier;
         hist    <= 1'b0;
         mcand_x <= {multiplicand[WIDTH-1], multiplicand};
      end else if (step_en) begin
         // arithmetic right shift of {acc, mreg, hist} as one word
         acc  <= {sum[ACC_W-1], sum[ACC_W-1:1]};
         mreg <= {sum[0], mreg[WIDTH-1:1]};
         hist <= mreg[0];
      end
   end

   assign product = {acc[WIDTH-1:0], mreg};

   // R5
   nop_shift_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && op == BOOTH_NOP) |=> (acc == {$past(acc[ACC_W-1]), $past(acc[ACC_W-1:1])}));

   // R5
   sign_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> (acc[ACC_W-1] == acc[ACC_W-2]));

   // R9
   mcand_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(mcand_x));

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
   import booth_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = ADDER_SHARED
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIDTH-1:0]   multiplicand,
   input  logic [WIDTH-1:0]   multiplier,
   output logic               busy,
   output logic               done,
   output logic [2*WIDTH-1:0] product
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("booth_seq_mul: WIDTH must be at least 2");
      end
      if (ADDER_STYLE != ADDER_SHARED && ADDER_STYLE != ADDER_DUAL) begin : g_bad_style
         $error("booth_seq_mul: unknown ADDER_STYLE");
      end
   endgenerate

   logic load_en;
   logic step_en;

   booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .busy    (busy),
      .done    (done),
      .load_en (load_en),
      .step_en (step_en)
   );

   booth_datapath #(.WIDTH(WIDTH), .ADDER_STYLE(ADDER_STYLE)) u_dp (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_en      (load_en),
      .step_en      (step_en),
      .multiplicand (multiplicand),
      .multiplier   (multiplier),
      .product      (product)
   );

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (!busy && !done));

endmodule

// File: tb/booth_seq_mul_test.sv
`timescale 1ns/1ps
module booth_seq_mul_test;

   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   mcand = '0;
   logic [W-1:0]   mplier = '0;
   logic           busy;
   logic           done;
   logic [2*W-1:0] product;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;  // 50 MHz

   booth_seq_mul #(.WIDTH(W)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .multiplicand (mcand),
      .multiplier   (mplier),
      .busy         (busy),
      .done         (done),
      .product      (product)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      logic signed [2*W-1:0] ea;
      logic signed [2*W-1:0] eb;
      ea = {{W{a[W-1]}}, a};
      eb = {{W{b[W-1]}}, b};
      return ea * eb;
   endfunction

   task automatic test_reset();
      @(negedge clk);
      check("R1 busy", 64'(busy), 64'd0);
      check("R1 done", 64'(done), 64'd0);
      check("R1 product", 64'(product), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy after release", 64'(busy), 64'd0);
      check("R1 done after release", 64'(done), 64'd0);
      check("R1 product after release", 64'(product), 64'd0);
   endtask

   // disturb: 1 = pulse start and change operands mid-run (R7, R9)
   task automatic run_mul(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit disturb);
      logic [2*W-1:0] exp;
      exp = ref_mul(a, b);
      @(negedge clk);
      mcand = a; mplier = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 busy after accept", 64'(busy), 64'd1);
      for (int k = 1; k <= W; k++) begin
         if (disturb && k == 2) begin
            start = 1'b1; mcand = ~a; mplier = b + 8'd3;
         end else if (disturb && k == 3) begin
            start = 1'b0;
         end
         @(negedge clk);
         if (k < W) begin
            check("R3 busy mid-run", 64'(busy), 64'd1);
            check("R4 no early done", 64'(done), 64'd0);
         end
      end
      start = 1'b0;
      check("R3 done at last step", 64'(done), 64'd1);
      check("R3 busy low at end", 64'(busy), 64'd0);
      check(req, 64'(product), 64'(exp));
      @(negedge clk);
      check("R4 done drops", 64'(done), 64'd0);
      check("R8 product held", 64'(product), 64'(exp));
      @(negedge clk);
      check("R8 product held idle", 64'(product), 64'(exp));
   endtask

   task automatic test_basic();
      run_mul("R5 3*5", 8'd3, 8'd5, 1'b0);
      run_mul("R5 -3*5", 8'hFD, 8'd5, 1'b0);
      run_mul("R5 7*-1", 8'd7, 8'hFF, 1'b0);
      run_mul("R5 -1*-1", 8'hFF, 8'hFF, 1'b0);
      run_mul("R5 alternating", 8'h55, 8'hAA, 1'b0);
      run_mul("R5 127*127", 8'h7F, 8'h7F, 1'b0);
      run_mul("R5 -37*91", 8'hDB, 8'd91, 1'b0);
   endtask

   task automatic test_extremes();
      run_mul("R6 min*min", 8'h80, 8'h80, 1'b0);
      check("R6 min*min value", 64'(product), 64'h4000);
      run_mul("R6 min*max", 8'h80, 8'h7F, 1'b0);
      run_mul("R6 max*min", 8'h7F, 8'h80, 1'b0);
   endtask

   task automatic test_zero();
      run_mul("R10 zero multiplier", 8'h9C, 8'h00, 1'b0);
      check("R10 zero value", 64'(product), 64'd0);
      run_mul("R10 zero multiplicand", 8'h00, 8'h80, 1'b0);
   endtask

   task automatic test_disturb();
      run_mul("R7 R9 start and operands during run", 8'hE5, 8'h3B, 1'b1);
      run_mul("R7 R9 second disturbed run", 8'h80, 8'h81, 1'b1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      test_reset();
      test_basic();
      test_extremes();
      test_zero();
      test_disturb();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule